// File: doc/BRIEF.md
# Storm Sensor Event and Interrupt Controller

This block sequences the operating modes of a storm sensor and raises its interrupts. A watchdog comparator upstream reports when the demodulated antenna signal crosses its threshold, and a validation block reports whether the signal was a strike or a man-made disturber. The controller moves between an off mode, a listening mode, a verification mode and two hold modes. A hold mode is a dead time that follows a classification. Its length depends on the kind of event: one second after a strike and one and a half seconds after a disturber. Time is counted in ticks of a slow timebase input.

The block writes a 4-bit interrupt code and drives an interrupt line. Four kinds of event can raise it: a strike, a disturber, a high noise level, and a strobe saying the distance estimate changed. Disturber interrupts can be masked. Strike interrupts are held back until a programmed number of strikes have fallen inside a sliding 15-minute window. The window keeps the timestamps of recent strikes in a 16-entry circular buffer. A read strobe from the register interface clears the interrupt line. Energy computation and distance estimation are outside this block; only the distance-changed strobe reaches it.

States and transitions: MODE_OFF goes to MODE_LISTEN when power-down is clear. MODE_LISTEN goes to MODE_VERIFY on a watchdog crossing. MODE_VERIFY goes to MODE_LHOLD when a strike is classified and to MODE_DHOLD when a disturber is classified. Each hold mode goes back to MODE_LISTEN when its tick count has elapsed. Any state goes to MODE_OFF while power-down is set.

Top module: `strike_event_ctrl`

## Requirements
- R1: During and after reset, `mode_o` is 0 (MODE_OFF), `irq_o` is 0 and `int_code_o` is 0000. With power-down low, `mode_o` becomes 1 (MODE_LISTEN) one cycle after reset is released.
- R2: In MODE_LISTEN, a cycle with `wd_cross_i` high puts `mode_o` at 2 (MODE_VERIFY) on the next cycle.
- R3: In MODE_VERIFY, a classification (`class_valid_i` high) with `class_light_i` high moves to MODE_LHOLD (3). The block stays there for exactly LIGHT_HOLD_TICKS ticks (default 10), ignoring `wd_cross_i`, and then returns to MODE_LISTEN.
- R4: A classification with `class_light_i` low moves to MODE_DHOLD (4). The block stays there for exactly DIST_HOLD_TICKS ticks (default 15), ignoring `wd_cross_i`, and then returns to MODE_LISTEN.
- R5: Interrupt codes are 1000 for a strike, 0100 for a disturber and 0001 for high noise. Each of these drives `irq_o` high one cycle after the event. While `irq_o` is low, the code is 0000.
- R6: With `cfg_mask_dist_i` high, a disturber classification leaves `irq_o` low. The mode still moves to MODE_DHOLD.
- R7: While `noise_hi_i` is high and the block is not powered down, `irq_o` is held high with code 0001 (unless a higher-priority code is held), and a read does not clear it.
- R8: A read strobe `int_rd_i` in a cycle with no event and noise low clears `irq_o` and sets the code to 0000 on the next cycle.
- R9: A `dist_chg_i` strobe with no other event raises `irq_o` with code 0000.
- R10: A strike raises its interrupt only if the strikes in the window, including this one, reach the threshold chosen by `cfg_min_strikes_i`: 00 gives 1, 01 gives 5, 10 gives 9 and 11 gives 16. The count includes the 17th and later strikes once the buffer is full.
- R11: A strike stops counting once its age reaches WINDOW_TICKS ticks (default 9000, that is 15 minutes).
- R12: A rising edge of `cfg_clr_stat_i` (held high normally, pulsed low then high) empties the strike window.
- R13: An event arriving while `irq_o` is high replaces the held code only if the new code ranks at least as high. The ranking is strike, then disturber, then noise, then distance change.
- R14: While `cfg_pwd_i` is high, `mode_o` is 0. Watchdog crossings, noise and distance strobes are ignored, and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow timebase tick, one cycle wide |
| wd_cross_i | input | 1 | Watchdog threshold crossing |
| class_valid_i | input | 1 | Classification result valid |
| class_light_i | input | 1 | 1 = strike, 0 = disturber |
| noise_hi_i | input | 1 | Noise floor above its threshold (level) |
| dist_chg_i | input | 1 | Distance estimate changed (strobe) |
| int_rd_i | input | 1 | Interrupt register read strobe |
| cfg_pwd_i | input | 1 | Power-down |
| cfg_mask_dist_i | input | 1 | Mask disturber interrupts |
| cfg_min_strikes_i | input | 2 | Strike-count threshold select |
| cfg_clr_stat_i | input | 1 | Clear statistics on rising edge |
| irq_o | output | 1 | Interrupt line |
| int_code_o | output | 4 | Interrupt code |
| mode_o | output | 3 | Current mode (0 off, 1 listen, 2 verify, 3 strike hold, 4 disturber hold) |

## Verification
Classifications are tried both as strikes and as disturbers, with the mask set and clear. This separates the two hold lengths, the two codes and the masking path, and a watchdog pulse inside each hold shows that the dead time holds. Runs of strikes are issued under each threshold setting, with one run spanning more than the window length. These show the threshold decode, the 16-entry wrap, expiry and the clear edge. Overlapping noise, distance and classification events are then presented without reads in between to expose the priority order. The same inputs are repeated under power-down to show that they are blocked.

// File: rtl/strike_pkg.sv
package strike_pkg;

    typedef enum logic [2:0] {
        MODE_OFF    = 3'd0,
        MODE_LISTEN = 3'd1,
        MODE_VERIFY = 3'd2,
        MODE_LHOLD  = 3'd3,
        MODE_DHOLD  = 3'd4
    } mode_e;

    localparam logic [3:0] CODE_NONE   = 4'b0000;
    localparam logic [3:0] CODE_NOISE  = 4'b0001;
    localparam logic [3:0] CODE_DISTRB = 4'b0100;
    localparam logic [3:0] CODE_STRIKE = 4'b1000;

    function automatic int strike_threshold(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 5;
            2'b10:   return 9;
            default: return 16;
        endcase
    endfunction

    function automatic logic [1:0] code_rank(input logic [3:0] code);
        case (code)
            CODE_STRIKE: return 2'd3;
            CODE_DISTRB: return 2'd2;
            CODE_NOISE:  return 2'd1;
            default:     return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/mode_fsm.sv
module mode_fsm
    import strike_pkg::*;
#(
    parameter int LIGHT_HOLD_TICKS = 10,
    parameter int DIST_HOLD_TICKS  = 15
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  tick_i,
    input  logic  wd_cross_i,
    input  logic  class_valid_i,
    input  logic  class_light_i,
    input  logic  cfg_pwd_i,
    output mode_e mode_o,
    output logic  active_o,
    output logic  strike_evt_o,
    output logic  disturb_evt_o
);
    localparam int MAX_HOLD = (LIGHT_HOLD_TICKS > DIST_HOLD_TICKS) ? LIGHT_HOLD_TICKS : DIST_HOLD_TICKS;
    localparam int HC_W     = $clog2(MAX_HOLD + 1);
    localparam logic [HC_W-1:0] LH_LAST = HC_W'(LIGHT_HOLD_TICKS - 1);
    localparam logic [HC_W-1:0] DH_LAST = HC_W'(DIST_HOLD_TICKS - 1);

    mode_e           state_q, state_d;
    logic [HC_W-1:0] hold_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_OFF:    state_d = MODE_LISTEN;
            MODE_LISTEN: if (wd_cross_i) state_d = MODE_VERIFY;
            MODE_VERIFY: if (class_valid_i) state_d = class_light_i ? MODE_LHOLD : MODE_DHOLD;
            MODE_LHOLD:  if (tick_i && hold_q == LH_LAST) state_d = MODE_LISTEN;
            MODE_DHOLD:  if (tick_i && hold_q == DH_LAST) state_d = MODE_LISTEN;
            default:     state_d = MODE_OFF;
        endcase
        if (cfg_pwd_i) state_d = MODE_OFF;
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= MODE_OFF;
        else         state_q <= state_d;
    end

    // dead-time tick counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 hold_q <= '0;
        else if (state_d != state_q) hold_q <= '0;
        else if (tick_i && (state_q == MODE_LHOLD || state_q == MODE_DHOLD))
            hold_q <= hold_q + 1'b1;
    end

    // outputs
    always_comb begin
        mode_o        = state_q;
        active_o      = (state_q != MODE_OFF) && !cfg_pwd_i;
        strike_evt_o  = 1'b0;
        disturb_evt_o = 1'b0;
        unique case (state_q)
            MODE_VERIFY: begin
                strike_evt_o  = active_o && class_valid_i && class_light_i;
                disturb_evt_o = active_o && class_valid_i && !class_light_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/strike_window.sv
module strike_window
    import strike_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int WINDOW_TICKS = 9000
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         tick_i,
    input  logic                         push_i,
    input  logic                         clear_i,
    input  logic [1:0]                   min_sel_i,
    output logic                         hit_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    // DEPTH must be a power of two so the index wraps naturally
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int TS_W  = $clog2(WINDOW_TICKS) + 2;
    localparam logic [TS_W-1:0]  WIN = TS_W'(WINDOW_TICKS);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [TS_W-1:0]  now_q;
    logic [TS_W-1:0]  stamp_q [DEPTH];
    logic [IDX_W-1:0] head_q;
    logic [CNT_W-1:0] count_q;
    logic [IDX_W-1:0] tail;
    logic [TS_W-1:0]  age;
    logic             expire;
    logic [CNT_W-1:0] live;

    assign tail   = head_q + IDX_W'(count_q);
    assign age    = now_q - stamp_q[head_q];
    assign expire = (count_q != '0) && (age >= WIN);
    assign live   = count_q - CNT_W'(expire);
    assign hit_o  = (int'(live) + 1) >= strike_threshold(min_sel_i);
    assign count_o = count_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     now_q <= '0;
        else if (tick_i) now_q <= now_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (push_i && !clear_i) stamp_q[tail] <= now_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            head_q  <= '0;
            count_q <= '0;
        end else if (clear_i) begin
            head_q  <= '0;
            count_q <= '0;
        end else begin
            unique case ({push_i, expire})
                2'b10: begin
                    if (count_q == FULL) head_q <= head_q + 1'b1;
                    else                 count_q <= count_q + 1'b1;
                end
                2'b11: head_q <= head_q + 1'b1;
                2'b01: begin
                    head_q  <= head_q + 1'b1;
                    count_q <= count_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import strike_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       strike_req_i,
    input  logic       disturb_req_i,
    input  logic       noise_req_i,
    input  logic       dist_req_i,
    input  logic       rd_i,
    output logic       irq_o,
    output logic [3:0] code_o
);
    logic       any_new;
    logic [3:0] new_code;
    logic       keep_old;

    always_comb begin
        any_new  = strike_req_i | disturb_req_i | noise_req_i | dist_req_i;
        if (strike_req_i)       new_code = CODE_STRIKE;
        else if (disturb_req_i) new_code = CODE_DISTRB;
        else if (noise_req_i)   new_code = CODE_NOISE;
        else                    new_code = CODE_NONE;
        keep_old = irq_o && (code_rank(code_o) > code_rank(new_code));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_o  <= 1'b0;
            code_o <= CODE_NONE;
        end else if (any_new) begin
            irq_o  <= 1'b1;
            code_o <= keep_old ? code_o : new_code;
        end else if (rd_i) begin
            irq_o  <= 1'b0;
            code_o <= CODE_NONE;
        end
    end

endmodule

// File: rtl/strike_event_ctrl.sv
module strike_event_ctrl
    import strike_pkg::*;
#(
    parameter int TICKS_PER_SEC = 10,
    parameter int DEPTH         = 16,
    parameter int WINDOW_SEC    = 900
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       wd_cross_i,
    input  logic       class_valid_i,
    input  logic       class_light_i,
    input  logic       noise_hi_i,
    input  logic       dist_chg_i,
    input  logic       int_rd_i,
    input  logic       cfg_pwd_i,
    input  logic       cfg_mask_dist_i,
    input  logic [1:0] cfg_min_strikes_i,
    input  logic       cfg_clr_stat_i,
    output logic       irq_o,
    output logic [3:0] int_code_o,
    output logic [2:0] mode_o
);
    localparam int LIGHT_HOLD_TICKS = TICKS_PER_SEC;
    localparam int DIST_HOLD_TICKS  = (TICKS_PER_SEC * 3) / 2;
    localparam int WINDOW_TICKS     = TICKS_PER_SEC * WINDOW_SEC;
    localparam int CNT_W            = $clog2(DEPTH + 1);

    mode_e            mode_w;
    logic             active_w;
    logic             strike_evt_w;
    logic             disturb_evt_w;
    logic             hit_w;
    logic [CNT_W-1:0] strike_cnt_w;
    logic             clr_prev_q;
    logic             clr_edge_w;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) clr_prev_q <= 1'b1;
        else         clr_prev_q <= cfg_clr_stat_i;
    end
    assign clr_edge_w = cfg_clr_stat_i && !clr_prev_q;

    mode_fsm #(
        .LIGHT_HOLD_TICKS(LIGHT_HOLD_TICKS),
        .DIST_HOLD_TICKS (DIST_HOLD_TICKS)
    ) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick_i),
        .wd_cross_i   (wd_cross_i),
        .class_valid_i(class_valid_i),
        .class_light_i(class_light_i),
        .cfg_pwd_i    (cfg_pwd_i),
        .mode_o       (mode_w),
        .active_o     (active_w),
        .strike_evt_o (strike_evt_w),
        .disturb_evt_o(disturb_evt_w)
    );

    strike_window #(
        .DEPTH       (DEPTH),
        .WINDOW_TICKS(WINDOW_TICKS)
    ) u_win (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .push_i   (strike_evt_w),
        .clear_i  (clr_edge_w),
        .min_sel_i(cfg_min_strikes_i),
        .hit_o    (hit_w),
        .count_o  (strike_cnt_w)
    );

    irq_arbiter u_irq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .strike_req_i (strike_evt_w && hit_w),
        .disturb_req_i(disturb_evt_w && !cfg_mask_dist_i),
        .noise_req_i  (noise_hi_i && active_w),
        .dist_req_i   (dist_chg_i && active_w),
        .rd_i         (int_rd_i),
        .irq_o        (irq_o),
        .code_o       (int_code_o)
    );

    assign mode_o = mode_w;

endmodule

// File: rtl/strike_event_chk.sv
module strike_event_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wd_cross_i,
    input logic       class_valid_i,
    input logic       noise_hi_i,
    input logic       dist_chg_i,
    input logic       int_rd_i,
    input logic       cfg_pwd_i,
    input logic       cfg_mask_dist_i,
    input logic       irq_o,
    input logic [3:0] int_code_o,
    input logic [2:0] mode_o,
    input logic       active_w,
    input logic       disturb_evt_w,
    input logic [4:0] strike_cnt_w
);
    // R5
    code_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (int_code_o == 4'b0000 || int_code_o == 4'b0001 ||
                   int_code_o == 4'b0100 || int_code_o == 4'b1000));

    // R5
    idle_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> (int_code_o == 4'b0000));

    // R14
    pwd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_pwd_i && !irq_o) |=> !irq_o);

    // R14
    pwd_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_pwd_i |=> (mode_o == 3'd0));

    // R8
    read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int_rd_i && !noise_hi_i && !class_valid_i && !dist_chg_i) |=> !irq_o);

    // R7
    noise_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (noise_hi_i && active_w) |=> irq_o);

    // R6
    mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (disturb_evt_w && cfg_mask_dist_i && !irq_o && !noise_hi_i && !dist_chg_i) |=> !irq_o);

    // R4
    dhold_deaf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd4 && wd_cross_i) |=> (mode_o != 3'd2));

    // R3
    lhold_deaf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd3 && wd_cross_i) |=> (mode_o != 3'd2));

    // R10
    count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strike_cnt_w <= 5'd16);

endmodule

bind strike_event_ctrl strike_event_chk u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wd_cross_i     (wd_cross_i),
    .class_valid_i  (class_valid_i),
    .noise_hi_i     (noise_hi_i),
    .dist_chg_i     (dist_chg_i),
    .int_rd_i       (int_rd_i),
    .cfg_pwd_i      (cfg_pwd_i),
    .cfg_mask_dist_i(cfg_mask_dist_i),
    .irq_o          (irq_o),
    .int_code_o     (int_code_o),
    .mode_o         (mode_o),
    .active_w       (active_w),
    .disturb_evt_w  (disturb_evt_w),
    .strike_cnt_w   (strike_cnt_w)
);

// File: tb/test_strike_event_ctrl.sv
`timescale 1ns/1ps
module test_strike_event_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, wd = 1'b0, cval = 1'b0, clight = 1'b0;
    logic       noise = 1'b0, dchg = 1'b0, rd = 1'b0;
    logic       pwd = 1'b0, mask = 1'b0, clr = 1'b1;
    logic [1:0] minsel = 2'b00;
    logic       irq;
    logic [3:0] code;
    logic [2:0] mode;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam int LH  = 10;
    localparam int DH  = 15;
    localparam int WIN = 9000;

    always #2.5 clk = ~clk;

    strike_event_ctrl i_strike_event_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wd_cross_i(wd),
        .class_valid_i(cval), .class_light_i(clight), .noise_hi_i(noise),
        .dist_chg_i(dchg), .int_rd_i(rd), .cfg_pwd_i(pwd),
        .cfg_mask_dist_i(mask), .cfg_min_strikes_i(minsel),
        .cfg_clr_stat_i(clr), .irq_o(irq), .int_code_o(code), .mode_o(mode)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(1);
            tick = 1'b0; step(1);
        end
    endtask

    task automatic do_read();
        rd = 1'b1; step(1); rd = 1'b0;
    endtask

    task automatic clear_stats();
        clr = 1'b0; step(1); clr = 1'b1; step(1);
    endtask

    // watchdog crossing then one classification; ends one cycle after it
    task automatic classify(input logic is_light);
        wd = 1'b1; step(1); wd = 1'b0;
        cval = 1'b1; clight = is_light; step(1);
        cval = 1'b0; clight = 1'b0;
    endtask

    task automatic strike_expect(input string req, input logic exp_irq);
        classify(1'b1);
        check(req, {7'd0, irq}, {7'd0, exp_irq});
        if (exp_irq) check(req, {4'd0, code}, 8'h08);
        do_read();
        ticks(LH);
    endtask

    task automatic t_reset();
        step(3);
        check("R1 reset mode", {5'd0, mode}, 8'd0);
        check("R1 reset irq", {7'd0, irq}, 8'd0);
        check("R1 reset code", {4'd0, code}, 8'd0);
        rst_n = 1'b1; step(1);
        check("R1 listen after reset", {5'd0, mode}, 8'd1);
    endtask

    task automatic t_lightning();
        wd = 1'b1; step(1); wd = 1'b0;
        check("R2 verify entered", {5'd0, mode}, 8'd2);
        cval = 1'b1; clight = 1'b1; step(1); cval = 1'b0; clight = 1'b0;
        check("R3 strike hold", {5'd0, mode}, 8'd3);
        check("R5 strike irq", {7'd0, irq}, 8'd1);
        check("R5 strike code", {4'd0, code}, 8'h08);
        do_read();
        check("R8 read clears irq", {7'd0, irq}, 8'd0);
        check("R8 read clears code", {4'd0, code}, 8'd0);
        ticks(LH - 1);
        wd = 1'b1; step(1); wd = 1'b0;
        check("R3 hold ignores watchdog", {5'd0, mode}, 8'd3);
        ticks(1);
        check("R3 back to listen", {5'd0, mode}, 8'd1);
    endtask

    task automatic t_disturber();
        classify(1'b0);
        check("R4 disturber hold", {5'd0, mode}, 8'd4);
        check("R5 disturber code", {4'd0, code}, 8'h04);
        check("R5 disturber irq", {7'd0, irq}, 8'd1);
        do_read();
        ticks(DH - 1);
        wd = 1'b1; step(1); wd = 1'b0;
        check("R4 hold ignores watchdog", {5'd0, mode}, 8'd4);
        ticks(1);
        check("R4 back to listen", {5'd0, mode}, 8'd1);
    endtask

    task automatic t_mask();
        mask = 1'b1;
        classify(1'b0);
        check("R6 masked no irq", {7'd0, irq}, 8'd0);
        check("R6 masked still holds", {5'd0, mode}, 8'd4);
        ticks(DH);
        mask = 1'b0;
    endtask

    task automatic t_noise_and_distance();
        noise = 1'b1; step(1);
        check("R7 noise irq", {7'd0, irq}, 8'd1);
        check("R7 noise code", {4'd0, code}, 8'h01);
        do_read(); step(1);
        check("R7 read ignored while noisy", {7'd0, irq}, 8'd1);
        noise = 1'b0; step(1);
        do_read();
        check("R8 read after noise", {7'd0, irq}, 8'd0);
        dchg = 1'b1; step(1); dchg = 1'b0;
        check("R9 distance irq", {7'd0, irq}, 8'd1);
        check("R9 distance code", {4'd0, code}, 8'h00);
        do_read();
        check("R9 cleared", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_priority();
        noise = 1'b1; step(1);
        dchg = 1'b1; step(1); dchg = 1'b0;
        check("R13 noise over distance", {4'd0, code}, 8'h01);
        classify(1'b0);
        check("R13 disturber over noise", {4'd0, code}, 8'h04);
        ticks(DH);
        step(2);
        check("R13 noise does not downgrade", {4'd0, code}, 8'h04);
        classify(1'b1);
        check("R13 strike over disturber", {4'd0, code}, 8'h08);
        noise = 1'b0; step(1);
        do_read();
        check("R13 cleared", {7'd0, irq}, 8'd0);
        ticks(LH);
    endtask

    task automatic t_threshold();
        clear_stats();
        minsel = 2'b01;
        for (int i = 0; i < 4; i++) strike_expect("R12 R10 below five", 1'b0);
        strike_expect("R10 fifth strike", 1'b1);
        clear_stats();
        strike_expect("R12 cleared window", 1'b0);
        clear_stats();
        minsel = 2'b10;
        for (int i = 0; i < 8; i++) strike_expect("R10 below nine", 1'b0);
        strike_expect("R10 ninth strike", 1'b1);
        clear_stats();
        minsel = 2'b11;
        for (int i = 0; i < 15; i++) strike_expect("R10 below sixteen", 1'b0);
        strike_expect("R10 sixteenth strike", 1'b1);
        strike_expect("R10 full buffer keeps count", 1'b1);
    endtask

    task automatic t_expiry();
        clear_stats();
        minsel = 2'b01;
        for (int i = 0; i < 4; i++) strike_expect("R11 fill", 1'b0);
        ticks(WIN + 10);
        strike_expect("R11 old strikes expired", 1'b0);
        for (int i = 0; i < 3; i++) strike_expect("R11 recount", 1'b0);
        strike_expect("R11 fifth fresh strike", 1'b1);
        minsel = 2'b00;
    endtask

    task automatic t_powerdown();
        pwd = 1'b1; step(1);
        check("R14 off mode", {5'd0, mode}, 8'd0);
        noise = 1'b1; dchg = 1'b1; wd = 1'b1; step(1);
        dchg = 1'b0; wd = 1'b0; step(1);
        check("R14 no irq", {7'd0, irq}, 8'd0);
        check("R14 watchdog ignored", {5'd0, mode}, 8'd0);
        noise = 1'b0; pwd = 1'b0; step(1);
        check("R14 listen on wake", {5'd0, mode}, 8'd1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_lightning();
                t_disturber();
                t_mask();
                t_noise_and_distance();
                t_priority();
                t_threshold();
                t_expiry();
                t_powerdown();
                done = 1'b1;
            end
            begin
                repeat (190000) @(posedge clk);
                if (!done) begin
                    n_tests++;
                    n_fail++;
                    $display("FAIL watchdog: actual hung expected finished");
                end
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule